// File: doc/BRIEF.md
# Grouped Interrupt Priority Arbiter

This block picks, for a single processor, the most urgent interrupt among a parameterised set of sources. A source is a candidate when it is both pending and enabled. The candidate with the numerically smallest 8-bit priority wins. The winner's group bit then decides which of two request lines it may drive: the normal interrupt line or the fast interrupt line. The block also reports the winner's ID as the highest pending interrupt. The register bus, acknowledge handling and targeting to several processors are outside it.

Three conditions gate the result.

- A global condition: at least one group must be enabled at the distributor, and at least one in the processor control.
- A priority mask: the winner's ID is reported only when its priority is below the mask.
- A running priority: a line is driven only when the winner is also more urgent than the running priority.

The line level is held in a registered three-state machine:

- `LINE_QUIET`: both lines low.
- `LINE_IRQ`: the normal line high.
- `LINE_FIQ`: the fast line high.

Every clock the machine takes the state the routing logic computes from the current inputs. The possible moves are QUIET→IRQ, QUIET→FIQ, IRQ→FIQ, FIQ→IRQ, any state→QUIET, or staying put. Reset forces `LINE_QUIET` and the ID 1023.

Top module: `grp_prio_arb`

## Requirements
- R1: While reset is asserted, and until the first evaluation after it, `hp_id` is 1023 and both `irq_o` and `fiq_o` are low.
- R2: If both distributor group enables are 0, or both processor group enables are 0, then `hp_id` is 1023 and both lines are low.
- R3: The winner is the pending and enabled source with the smallest priority value. Source k's priority is taken from `src_prio[8k+7:8k]`. On equal priorities the lowest ID wins.
- R4: `hp_id` shows the winner's ID only when the winner's priority is strictly less than `prio_mask`. Otherwise `hp_id` is 1023 and both lines are low. The value 1023 means that nothing is pending.
- R5: A line is asserted only when the winner's priority is also strictly less than `run_prio`. The ID is reported even when no line is asserted.
- R6: Source k belongs to group 0 when `src_grp[k]`=0 and to group 1 when it is 1. A line is asserted only if the winner's group is enabled both at the distributor and in the processor control. A winner in a disabled group still blocks every other source.
- R7: A group-0 winner drives `fiq_o` when `cpu_fast_en`=1. Every other winner that passes R4 to R6 drives `irq_o`.
- R8: `irq_o` and `fiq_o` are never high together.
- R9: Outputs are registered: they reflect the inputs sampled at the previous rising clock edge, and they do not change between edges.
- R10: A source that is pending but not enabled, or enabled but not pending, never wins, whatever its priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | NUM_SRC | Per-source pending |
| src_en | input | NUM_SRC | Per-source enable |
| src_grp | input | NUM_SRC | Per-source group (0 or 1) |
| src_prio | input | 8*NUM_SRC | Per-source priority, source k at [8k+7:8k] |
| dist_g0_en | input | 1 | Distributor group-0 enable |
| dist_g1_en | input | 1 | Distributor group-1 enable |
| cpu_g0_en | input | 1 | Processor group-0 enable |
| cpu_g1_en | input | 1 | Processor group-1 enable |
| cpu_fast_en | input | 1 | Route group 0 to the fast line |
| prio_mask | input | 8 | Priority mask |
| run_prio | input | 8 | Current running priority |
| hp_id | output | 10 | Highest pending ID, 1023 if none |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |

## Verification
A corrupted line state would appear on `irq_o`/`fiq_o` one clock after the inputs that should have produced a different state. It would show as a line in the wrong group or both lines high, and it would be seen by the next sample. A fault in the selection tree would surface in `hp_id` within the same single clock of latency, most visibly on ties and on winners at the highest ID. The random stimulus keeps priorities coarse, so that ties and mask or running-priority equality occur often. Every sample is compared against a scan computed in the bench.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0] NO_PEND_ID = ID_W'(1023);

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic              grp;
        logic [ID_W-1:0]   id;
    } cand_t;

    typedef enum logic [1:0] {
        LINE_QUIET = 2'b00,
        LINE_IRQ   = 2'b01,
        LINE_FIQ   = 2'b10
    } line_st_e;
endpackage

// File: rtl/gpa_tree.sv
module gpa_tree
    import gpa_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC-1:0]        src_grp,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    output cand_t                     best
);
    localparam int LVL    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 0;
    localparam int LEAVES = 1 << LVL;
    localparam int NODES  = 2 * LEAVES - 1;

    cand_t node [NODES];

    // leaves in heap order: left subtrees always hold lower IDs
    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < NUM_SRC) begin : g_real
            assign node[LEAVES-1+k] = '{vld:  src_pend[k] & src_en[k],
                                        prio: src_prio[k*PRIO_W +: PRIO_W],
                                        grp:  src_grp[k],
                                        id:   ID_W'(k)};
        end else begin : g_pad
            assign node[LEAVES-1+k] = '0;
        end
    end

    for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
        logic take_left;
        assign take_left = node[2*i+1].vld &&
                           (!node[2*i+2].vld || (node[2*i+1].prio <= node[2*i+2].prio));
        assign node[i] = take_left ? node[2*i+1] : node[2*i+2];
    end

    assign best = node[0];
endmodule

// File: rtl/gpa_route.sv
module gpa_route
    import gpa_pkg::*;
(
    input  cand_t             best,
    input  logic              dist_g0_en,
    input  logic              dist_g1_en,
    input  logic              cpu_g0_en,
    input  logic              cpu_g1_en,
    input  logic              cpu_fast_en,
    input  logic [PRIO_W-1:0] prio_mask,
    input  logic [PRIO_W-1:0] run_prio,
    output line_st_e          nxt_state,
    output logic [ID_W-1:0]   nxt_id
);
    logic any_grp, below_mask, below_run, grp_ok, fire, use_fast;

    always_comb begin
        any_grp    = (dist_g0_en | dist_g1_en) & (cpu_g0_en | cpu_g1_en);
        below_mask = best.vld && (best.prio < prio_mask);
        below_run  = best.prio < run_prio;
        grp_ok     = best.grp ? (dist_g1_en & cpu_g1_en) : (dist_g0_en & cpu_g0_en);
        fire       = any_grp & below_mask & below_run & grp_ok;
        use_fast   = ~best.grp & cpu_fast_en;
        nxt_id     = (any_grp && below_mask) ? best.id : NO_PEND_ID;
        unique case ({fire, use_fast})
            2'b10:   nxt_state = LINE_IRQ;
            2'b11:   nxt_state = LINE_FIQ;
            default: nxt_state = LINE_QUIET;
        endcase
    end
endmodule

// File: rtl/grp_prio_arb.sv
module grp_prio_arb
    import gpa_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_pend,
    input  logic [NUM_SRC-1:0]        src_en,
    input  logic [NUM_SRC-1:0]        src_grp,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic                      dist_g0_en,
    input  logic                      dist_g1_en,
    input  logic                      cpu_g0_en,
    input  logic                      cpu_g1_en,
    input  logic                      cpu_fast_en,
    input  logic [PRIO_W-1:0]         prio_mask,
    input  logic [PRIO_W-1:0]         run_prio,
    output logic [ID_W-1:0]           hp_id,
    output logic                      irq_o,
    output logic                      fiq_o
);
    cand_t           best;
    line_st_e        state_q, state_d;
    logic [ID_W-1:0] id_q, id_d;

    gpa_tree #(.NUM_SRC(NUM_SRC)) u_tree (
        .src_pend (src_pend),
        .src_en   (src_en),
        .src_grp  (src_grp),
        .src_prio (src_prio),
        .best     (best)
    );

    gpa_route u_route (
        .best        (best),
        .dist_g0_en  (dist_g0_en),
        .dist_g1_en  (dist_g1_en),
        .cpu_g0_en   (cpu_g0_en),
        .cpu_g1_en   (cpu_g1_en),
        .cpu_fast_en (cpu_fast_en),
        .prio_mask   (prio_mask),
        .run_prio    (run_prio),
        .nxt_state   (state_d),
        .nxt_id      (id_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
            id_q    <= NO_PEND_ID;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    always_comb begin
        irq_o = 1'b0;
        fiq_o = 1'b0;
        unique case (state_q)
            LINE_QUIET: ;
            LINE_IRQ:   irq_o = 1'b1;
            LINE_FIQ:   fiq_o = 1'b1;
            default:    ;
        endcase
        hp_id = id_q;
    end
endmodule

// File: rtl/gpa_chk.sv
module gpa_chk
    import gpa_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SRC-1:0]        src_pend,
    input logic [NUM_SRC-1:0]        src_en,
    input logic [NUM_SRC-1:0]        src_grp,
    input logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input logic                      dist_g0_en,
    input logic                      dist_g1_en,
    input logic                      cpu_g0_en,
    input logic                      cpu_g1_en,
    input logic                      cpu_fast_en,
    input logic [PRIO_W-1:0]         prio_mask,
    input logic [PRIO_W-1:0]         run_prio,
    input logic [ID_W-1:0]           hp_id,
    input logic                      irq_o,
    input logic                      fiq_o
);
    logic [NUM_SRC*PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]         run_q;
    logic [PRIO_W-1:0]         sel_prio;
    logic                      id_in_range;

    always_ff @(posedge clk) begin
        prio_q <= src_prio;
        run_q  <= run_prio;
    end

    always_comb begin
        id_in_range = int'(hp_id) < NUM_SRC;
        sel_prio    = id_in_range ? prio_q[int'(hp_id)*PRIO_W +: PRIO_W] : '1;
    end

    // R8
    lines_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_o, fiq_o}));

    // R2
    gdis_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((dist_g0_en | dist_g1_en) & (cpu_g0_en | cpu_g1_en))
        |=> (hp_id == NO_PEND_ID) && !irq_o && !fiq_o);

    // R4
    line_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (hp_id != NO_PEND_ID));

    // R7
    fiq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(cpu_fast_en && dist_g0_en && cpu_g0_en));

    // R6
    irq_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past((dist_g0_en && cpu_g0_en) || (dist_g1_en && cpu_g1_en)));

    // R5
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o || fiq_o) && id_in_range) |-> (sel_prio < run_q));
endmodule

bind grp_prio_arb gpa_chk #(.NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/sim_grp_prio_arb.sv
`timescale 1ns/1ps
module sim_grp_prio_arb;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0]   pend, en, grp;
    logic [N*8-1:0] prio;
    logic d0, d1, c0, c1, fen;
    logic [7:0] pmask, rprio;
    logic [9:0] hp_id;
    logic irq, fiq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    grp_prio_arb #(.NUM_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .src_pend(pend), .src_en(en), .src_grp(grp),
        .src_prio(prio), .dist_g0_en(d0), .dist_g1_en(d1), .cpu_g0_en(c0),
        .cpu_g1_en(c1), .cpu_fast_en(fen), .prio_mask(pmask), .run_prio(rprio),
        .hp_id(hp_id), .irq_o(irq), .fiq_o(fiq)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model(output int id, output int ir, output int fq);
        int best = 256;
        int bid = -1;
        for (int k = 0; k < N; k++) begin
            if (pend[k] && en[k] && int'(prio[k*8 +: 8]) < best) begin
                best = int'(prio[k*8 +: 8]);
                bid = k;
            end
        end
        id = 1023; ir = 0; fq = 0;
        if ((d0 || d1) && (c0 || c1) && bid >= 0 && best < int'(pmask)) begin
            id = bid;
            if (best < int'(rprio)) begin
                if (grp[bid] ? (d1 && c1) : (d0 && c0)) begin
                    if (!grp[bid] && fen) fq = 1;
                    else ir = 1;
                end
            end
        end
    endfunction

    task automatic step(string req);
        int eid, eir, efq;
        model(eid, eir, efq);
        @(posedge clk);
        @(negedge clk);
        chk(req, "hp_id", int'(hp_id), eid);
        chk(req, "irq_o", int'(irq), eir);
        chk(req, "fiq_o", int'(fiq), efq);
    endtask

    task automatic clear_all();
        pend = '0; en = '0; grp = '0; prio = '1;
        d0 = 1; d1 = 1; c0 = 1; c1 = 1; fen = 1;
        pmask = 8'hFF; rprio = 8'hFF;
    endtask

    task automatic set_src(int k, bit p, bit e, bit g, logic [7:0] pr);
        pend[k] = p; en[k] = e; grp[k] = g; prio[k*8 +: 8] = pr;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the run finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        clear_all();
        set_src(4, 1, 1, 0, 8'h10);
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "hp_id", int'(hp_id), 1023);
        chk("R1", "irq_o", int'(irq), 0);
        chk("R1", "fiq_o", int'(fiq), 0);
        rst_n = 1;

        // R7 group 0 with fast enable goes to FIQ
        clear_all(); set_src(5, 1, 1, 0, 8'h40);
        step("R7");
        // R7 fast enable off goes to IRQ
        fen = 0; step("R7");
        // R7 group 1 goes to IRQ even with fast enable
        fen = 1; grp[5] = 1; step("R7");

        // R3 tie broken to lowest ID
        clear_all(); set_src(9, 1, 1, 1, 8'h20); set_src(3, 1, 1, 1, 8'h20);
        step("R3");
        chk("R3", "tie id", int'(hp_id), 3);
        // R3 smaller value at a higher ID wins
        set_src(20, 1, 1, 1, 8'h10);
        step("R3");
        chk("R3", "low value id", int'(hp_id), 20);
        // R3 boundary: last source wins
        set_src(N-1, 1, 1, 0, 8'h00);
        step("R3");

        // R4 mask equal to priority hides the winner
        clear_all(); set_src(7, 1, 1, 1, 8'h30); pmask = 8'h30;
        step("R4");
        pmask = 8'h31; step("R4");

        // R5 running priority equal: ID reported, no line
        rprio = 8'h30; step("R5");
        rprio = 8'h31; step("R5");

        // R6 winner group disabled at the processor blocks a lower source
        clear_all(); set_src(2, 1, 1, 1, 8'h10); set_src(8, 1, 1, 0, 8'h50);
        c1 = 0; step("R6");
        // R6 disabled at distributor
        c1 = 1; d1 = 0; step("R6");

        // R2 global disable: distributor side, then processor side
        clear_all(); set_src(1, 1, 1, 0, 8'h05);
        d0 = 0; d1 = 0; step("R2");
        d0 = 1; c0 = 0; c1 = 0; step("R2");

        // R10 pending but disabled, and enabled but not pending, never win
        clear_all(); set_src(0, 1, 0, 0, 8'h00); set_src(1, 0, 1, 0, 8'h00);
        set_src(6, 1, 1, 1, 8'h80);
        step("R10");
        chk("R10", "id", int'(hp_id), 6);

        // R9 output holds until the next edge, then follows
        clear_all(); set_src(12, 1, 1, 0, 8'h22); fen = 0;
        step("R9");
        set_src(12, 0, 1, 0, 8'h22);
        #1;
        chk("R9", "hold id", int'(hp_id), 12);
        chk("R9", "hold irq", int'(irq), 1);
        step("R9");

        // random mix, R3 main function, R8 checked on each sample
        for (int it = 0; it < 400; it++) begin
            for (int k = 0; k < N; k++) begin
                pend[k] = ($urandom_range(0, 3) != 0);
                en[k]   = ($urandom_range(0, 3) != 0);
                grp[k]  = $urandom_range(0, 1);
                prio[k*8 +: 8] = 8'(($urandom_range(0, 15) << 4) | ($urandom_range(0, 3) == 0 ? 8'h8 : 8'h0));
            end
            if ($urandom_range(0, 1) == 0) pend = pend & ($urandom() & $urandom());
            d0 = ($urandom_range(0, 7) != 0); d1 = ($urandom_range(0, 7) != 0);
            c0 = ($urandom_range(0, 7) != 0); c1 = ($urandom_range(0, 7) != 0);
            fen = $urandom_range(0, 1);
            pmask = 8'($urandom_range(0, 16) << 4);
            rprio = 8'($urandom_range(0, 16) << 4);
            if ($urandom_range(0, 3) == 0) pmask = 8'hFF;
            step("R3");
            chk("R8", "both lines", int'(irq & fiq), 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule